// File: doc/BRIEF.md
# Configurable Up/Down Event Timer

A 16-bit up/down counter whose count source, direction source and internal rate come from an 8-bit control word. It can step on the divided system clock, on both edges of an external clock pin, on the overflow pulse of a companion timer, or on the companion's own step strobe, in which case it also follows that timer's direction. It can also decode the external clock and direction pins as a 4x quadrature pair. The count wraps, and single-cycle overflow and underflow pulses mark the wrap points. Everything runs in the system clock domain: external edges, companion pulses and prescaler ticks each act as a one-cycle count enable.

Two finite-state structures shape the behaviour. The quadrature decoder holds the last sampled phase in one of four states, PH_00, PH_10, PH_11 and PH_01. Every cycle it moves to the phase now on the pins. A move along PH_00→PH_10→PH_11→PH_01→PH_00 is a forward transition and counts up. A move along the reverse ring is a backward transition and counts down. A move between opposite corners (PH_00↔PH_11, PH_10↔PH_01) is a skip transition: the decoder resynchronises to the new phase and produces no count. Staying in the same phase is a hold transition. The source selector treats the 3-bit mode field as eight named states: INT_REG, EXT_REG, INT_PIN, EXT_PIN, CASCADE, EXT_REG_ALT, LOCKSTEP and QUAD. A control write moves the selector from one mode to another on the next clock.

Top module: `updn_evt_timer`

## Requirements
- R1: After reset the control word is 00h, the count is 0000h, `ovf_o` and `unf_o` are low, and the count does not move.
- R2: While control bit 7 (enable) is 0, the count holds, whatever clock, pin or companion activity is present.
- R3: In modes 000 and 010 the count steps once every 4·2^P system cycles, where P is control bits 2:0. Every control write restarts the divider, so the first step lands 4·2^P cycles after the enabling write.
- R4: In modes 000, 001, 101 and 100, control bit 6 sets the direction (1 = up, 0 = down), and the direction pin is ignored.
- R5: In modes 001, 101, 011 each rising and each falling edge of `ext_clk_i` gives one step. The step shows on `count_o` three cycles after the pin change: two synchroniser flops and one edge register.
- R6: In modes 010 and 011 the synchronised level of `ext_dir_i` sets the direction (1 = up), and control bit 6 is ignored.
- R7: In mode 100 each cycle with `peer_ovf_i` high gives one step.
- R8: In mode 110 each cycle with `peer_tick_i` high gives one step in the direction of `peer_up_i` (1 = up), and control bit 6 is ignored.
- R9: In mode 111 the pins form the phase (A = `ext_clk_i`, B = `ext_dir_i`). Order 00→10→11→01→00 counts up one per transition, the reverse order counts down, and a change of both pins at once gives no step.
- R10: The count wraps modulo 2^16. Stepping up from FFFFh raises `ovf_o`, and stepping down from 0000h raises `unf_o`, each for exactly the cycle in which the wrapped value first appears.
- R11: `cnt_we` loads `cnt_wdata` on the next clock and overrides a step in the same cycle. Control writes never alter the count, and the count otherwise changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word: [7] enable, [6] direction, [5:3] mode, [2:0] prescale code |
| cnt_we | input | 1 | Count load strobe |
| cnt_wdata | input | 16 | Count load value |
| ext_clk_i | input | 1 | External clock pin (quadrature phase A) |
| ext_dir_i | input | 1 | External direction pin (quadrature phase B) |
| peer_ovf_i | input | 1 | Companion timer overflow pulse |
| peer_tick_i | input | 1 | Companion timer step strobe |
| peer_up_i | input | 1 | Companion timer direction, 1 = up |
| count_o | output | 16 | Current count |
| ovf_o | output | 1 | One-cycle overflow pulse |
| unf_o | output | 1 | One-cycle underflow pulse |

## Verification
The assertions assume that the companion strobes are already synchronous to `clk`. They also assume that the count moves only by a load or by a single step per cycle, which holds only if every pin level lasts at least one clock so the synchroniser sees each edge. The stimulus changes every pin at a falling clock edge and holds each level for four cycles or more. It pulses companion strobes for exactly one cycle with gaps between them, and it stops the timer before it loads the count or changes pin levels for the next case.

// File: rtl/updn_tmr_pkg.sv
package updn_tmr_pkg;

    localparam int PRE_W = 3;

    typedef enum logic [2:0] {
        INT_REG     = 3'b000,
        EXT_REG     = 3'b001,
        INT_PIN     = 3'b010,
        EXT_PIN     = 3'b011,
        CASCADE     = 3'b100,
        EXT_REG_ALT = 3'b101,
        LOCKSTEP    = 3'b110,
        QUAD        = 3'b111
    } src_mode_e;

    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } quad_ph_e;

    typedef struct packed {
        logic             run;
        logic             up;
        src_mode_e        mode;
        logic [PRE_W-1:0] pre;
    } ctl_t;

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] sh_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-2:0], pin_i[g]};
        end

        assign lvl_o[g] = sh_q[STAGES-1];
    end

endmodule

// File: rtl/tmr_quad_fsm.sv
module tmr_quad_fsm
    import updn_tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    input  logic b_i,
    output logic step_o,
    output logic up_o
);

    quad_ph_e ph_q;
    quad_ph_e ph_now;

    assign ph_now = quad_ph_e'({a_i, b_i});

    // state register: always follows the sampled phase, so a skip resynchronises
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_00;
        else        ph_q <= ph_now;
    end

    // outputs: forward ring counts up, reverse ring counts down, skip and hold give nothing
    always_comb begin
        step_o = 1'b0;
        up_o   = 1'b0;
        unique case (ph_q)
            PH_00: begin
                if (ph_now == PH_10)      begin step_o = 1'b1; up_o = 1'b1; end
                else if (ph_now == PH_01) begin step_o = 1'b1; up_o = 1'b0; end
            end
            PH_10: begin
                if (ph_now == PH_11)      begin step_o = 1'b1; up_o = 1'b1; end
                else if (ph_now == PH_00) begin step_o = 1'b1; up_o = 1'b0; end
            end
            PH_11: begin
                if (ph_now == PH_01)      begin step_o = 1'b1; up_o = 1'b1; end
                else if (ph_now == PH_10) begin step_o = 1'b1; up_o = 1'b0; end
            end
            PH_01: begin
                if (ph_now == PH_00)      begin step_o = 1'b1; up_o = 1'b1; end
                else if (ph_now == PH_11) begin step_o = 1'b1; up_o = 1'b0; end
            end
        endcase
    end

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int BASE_LOG = 2,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    localparam int DIV_W = BASE_LOG + (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask = '0;
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < BASE_LOG + int'(sel_i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 div_q <= '0;
        else if (clr_i || !run_i)   div_q <= '0;
        else                        div_q <= div_q + 1'b1;
    end

    assign tick_o = run_i && ((div_q & mask) == mask);

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  logic         step_i,
    input  logic         up_i,
    output logic [W-1:0] cnt_o,
    output logic         ovf_o,
    output logic         unf_o
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
            ovf_o <= 1'b0;
            unf_o <= 1'b0;
        end else begin
            ovf_o <= 1'b0;
            unf_o <= 1'b0;
            if (ld_i) begin
                cnt_o <= ld_val_i;
            end else if (step_i) begin
                if (up_i) begin
                    cnt_o <= cnt_o + 1'b1;
                    ovf_o <= (cnt_o == TOP);
                end else begin
                    cnt_o <= cnt_o - 1'b1;
                    unf_o <= (cnt_o == '0);
                end
            end
        end
    end

endmodule

// File: rtl/updn_evt_timer.sv
module updn_evt_timer
    import updn_tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int BASE_LOG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             ext_clk_i,
    input  logic             ext_dir_i,
    input  logic             peer_ovf_i,
    input  logic             peer_tick_i,
    input  logic             peer_up_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             unf_o
);

    ctl_t       ctl_q;
    logic [1:0] pin_lvl;
    logic       clk_prev_q;
    logic       ext_edge;
    logic       pre_tick;
    logic       pre_run;
    logic       q_step;
    logic       q_up;
    logic       evt;
    logic       dir_up;
    logic       step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_we) ctl_q <= ctl_t'(ctl_wdata);
    end

    tmr_pin_sync #(.W(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({ext_dir_i, ext_clk_i}),
        .lvl_o (pin_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_prev_q <= 1'b0;
        else        clk_prev_q <= pin_lvl[0];
    end

    assign ext_edge = pin_lvl[0] ^ clk_prev_q;

    assign pre_run = ctl_q.run &&
                     (ctl_q.mode == INT_REG || ctl_q.mode == INT_PIN);

    tmr_prescale #(.BASE_LOG(BASE_LOG), .SEL_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (ctl_we),
        .run_i  (pre_run),
        .sel_i  (ctl_q.pre),
        .tick_o (pre_tick)
    );

    tmr_quad_fsm u_quad (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_i    (pin_lvl[0]),
        .b_i    (pin_lvl[1]),
        .step_o (q_step),
        .up_o   (q_up)
    );

    // source and direction selection per mode
    always_comb begin
        evt    = 1'b0;
        dir_up = ctl_q.up;
        unique case (ctl_q.mode)
            INT_REG:     begin evt = pre_tick;    dir_up = ctl_q.up;   end
            EXT_REG:     begin evt = ext_edge;    dir_up = ctl_q.up;   end
            INT_PIN:     begin evt = pre_tick;    dir_up = pin_lvl[1]; end
            EXT_PIN:     begin evt = ext_edge;    dir_up = pin_lvl[1]; end
            CASCADE:     begin evt = peer_ovf_i;  dir_up = ctl_q.up;   end
            EXT_REG_ALT: begin evt = ext_edge;    dir_up = ctl_q.up;   end
            LOCKSTEP:    begin evt = peer_tick_i; dir_up = peer_up_i;  end
            QUAD:        begin evt = q_step;      dir_up = q_up;       end
        endcase
    end

    assign step = ctl_q.run && evt;

    tmr_count_core #(.W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (cnt_we),
        .ld_val_i (cnt_wdata),
        .step_i   (step),
        .up_i     (dir_up),
        .cnt_o    (count_o),
        .ovf_o    (ovf_o),
        .unf_o    (unf_o)
    );

endmodule

// File: rtl/updn_evt_timer_chk.sv
module updn_evt_timer_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run_i,
    input logic          cnt_we_i,
    input logic [CW-1:0] cnt_wdata_i,
    input logic [CW-1:0] count_i,
    input logic          ovf_i,
    input logic          unf_i
);

    localparam logic [CW-1:0] TOP = '1;

    // R2
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !cnt_we_i) |=> $stable(count_i));

    // R11
    load_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we_i |=> (count_i == $past(cnt_wdata_i)));

    // R11
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we_i |=> (count_i == $past(count_i) ||
                       count_i == CW'($past(count_i) + 1'b1) ||
                       count_i == CW'($past(count_i) - 1'b1)));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i |-> (count_i == '0 && $past(count_i) == TOP));

    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_i |-> (count_i == TOP && $past(count_i) == '0));

    // R10
    wrap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_i && unf_i));

endmodule

bind updn_evt_timer updn_evt_timer_chk #(.CW(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (ctl_q.run),
    .cnt_we_i    (cnt_we),
    .cnt_wdata_i (cnt_wdata),
    .count_i     (count_o),
    .ovf_i       (ovf_o),
    .unf_i       (unf_o)
);

// File: tb/updn_evt_timer_tb.sv
module updn_evt_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_we;
    logic [7:0]  ctl_wdata;
    logic        cnt_we;
    logic [15:0] cnt_wdata;
    logic        ext_clk_i;
    logic        ext_dir_i;
    logic        peer_ovf_i;
    logic        peer_tick_i;
    logic        peer_up_i;
    logic [15:0] count_o;
    logic        ovf_o;
    logic        unf_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    updn_evt_timer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_we      (ctl_we),
        .ctl_wdata   (ctl_wdata),
        .cnt_we      (cnt_we),
        .cnt_wdata   (cnt_wdata),
        .ext_clk_i   (ext_clk_i),
        .ext_dir_i   (ext_dir_i),
        .peer_ovf_i  (peer_ovf_i),
        .peer_tick_i (peer_tick_i),
        .peer_up_i   (peer_up_i),
        .count_o     (count_o),
        .ovf_o       (ovf_o),
        .unf_o       (unf_o)
    );

    // {req[62:59], ctl[58:51], kind[50:49], lvl[48], n[47:32], start[31:16], expect[15:0]}
    // kind 0: internal run for n cycles, 1: n pin toggles, 2: n companion overflows, 3: n companion strobes
    localparam int NV = 13;
    localparam logic [62:0] VEC [NV] = '{
        {4'd3, 8'hC0, 2'd0, 1'b0, 16'd40,   16'h0000, 16'h000A}, // R3 R4 up, /4
        {4'd3, 8'h82, 2'd0, 1'b0, 16'd64,   16'd100,  16'd96  }, // R3 R4 down, /16
        {4'd3, 8'h87, 2'd0, 1'b0, 16'd1030, 16'd5,    16'd3   }, // R3 /512
        {4'd6, 8'h91, 2'd0, 1'b1, 16'd80,   16'h0000, 16'd10  }, // R6 pin up overrides bit
        {4'd6, 8'hD0, 2'd0, 1'b0, 16'd20,   16'd20,   16'd15  }, // R6 pin down overrides bit
        {4'd5, 8'hC8, 2'd1, 1'b0, 16'd7,    16'h0000, 16'd7   }, // R5 R4 pin ignored
        {4'd5, 8'hA8, 2'd1, 1'b0, 16'd4,    16'd10,   16'd6   }, // R5 alternate code
        {4'd6, 8'h98, 2'd1, 1'b1, 16'd6,    16'h0000, 16'd6   }, // R6 ext clock, pin dir
        {4'd7, 8'hE0, 2'd2, 1'b0, 16'd5,    16'hFFFE, 16'h0003}, // R7 with wrap
        {4'd8, 8'hB0, 2'd3, 1'b1, 16'd9,    16'h0000, 16'd9   }, // R8 follows companion up
        {4'd8, 8'hB0, 2'd3, 1'b0, 16'd3,    16'h0001, 16'hFFFE}, // R8 follows companion down
        {4'd2, 8'h48, 2'd1, 1'b0, 16'd5,    16'h1234, 16'h1234}, // R2 pin edges, stopped
        {4'd2, 8'h40, 2'd0, 1'b0, 16'd100,  16'h0042, 16'h0042}  // R2 internal, stopped
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wdata = v;
        ctl_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ctl_we    = 1'b0;
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        cnt_wdata = v;
        cnt_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cnt_we    = 1'b0;
    endtask

    task automatic quad_step(input logic a, input logic b, input logic [15:0] exp, input string what);
        ext_clk_i = a;
        ext_dir_i = b;
        idle(4);
        check(what, count_o, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1..: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0; cnt_we = 1'b0; cnt_wdata = '0;
        ext_clk_i = 1'b0; ext_dir_i = 1'b0;
        peer_ovf_i = 1'b0; peer_tick_i = 1'b0; peer_up_i = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 count after reset", count_o, 32'h0);
        check("R1 ovf after reset", ovf_o, 32'h0);
        check("R1 unf after reset", unf_o, 32'h0);
        idle(40);
        check("R1 stopped after reset", count_o, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            automatic logic [62:0] v = VEC[i];
            automatic logic [7:0]  c = v[58:51];
            wr_ctl(8'h00);
            ext_dir_i = v[48];
            peer_up_i = v[48];
            idle(5);
            wr_cnt(v[31:16]);
            wr_ctl(c);
            unique case (v[50:49])
                2'd0: begin
                    idle(int'(v[47:32]) - 1);
                    wr_ctl({1'b0, c[6:0]});
                end
                2'd1: begin
                    for (int k = 0; k < int'(v[47:32]); k++) begin
                        ext_clk_i = ~ext_clk_i;
                        idle(4);
                    end
                    idle(4);
                end
                2'd2: begin
                    for (int k = 0; k < int'(v[47:32]); k++) begin
                        peer_ovf_i = 1'b1; idle(1); peer_ovf_i = 1'b0; idle(2);
                    end
                end
                default: begin
                    for (int k = 0; k < int'(v[47:32]); k++) begin
                        peer_tick_i = 1'b1; idle(1); peer_tick_i = 1'b0; idle(2);
                    end
                end
            endcase
            check($sformatf("R%0d vector %0d", v[62:59], i), count_o, v[15:0]);
        end

        // R3 first step lands exactly four cycles after the enabling write
        wr_ctl(8'h00); wr_cnt(16'h0000);
        wr_ctl(8'hC0);
        idle(3);
        check("R3 no step before period", count_o, 32'h0);
        idle(1);
        check("R3 step at period", count_o, 32'h1);

        // R5 three-cycle latency from pin change
        wr_ctl(8'h00); idle(5); wr_cnt(16'h0000);
        wr_ctl(8'hC8);
        ext_clk_i = ~ext_clk_i;
        idle(2);
        check("R5 not yet counted", count_o, 32'h0);
        idle(1);
        check("R5 counted on third edge", count_o, 32'h1);

        // R9 quadrature
        wr_ctl(8'h00);
        ext_clk_i = 1'b0; ext_dir_i = 1'b0;
        idle(6);
        wr_cnt(16'd100);
        wr_ctl(8'hB8);
        quad_step(1'b1, 1'b0, 16'd101, "R9 fwd 00->10");
        quad_step(1'b1, 1'b1, 16'd102, "R9 fwd 10->11");
        quad_step(1'b0, 1'b1, 16'd103, "R9 fwd 11->01");
        quad_step(1'b0, 1'b0, 16'd104, "R9 fwd 01->00");
        quad_step(1'b0, 1'b1, 16'd103, "R9 back 00->01");
        quad_step(1'b1, 1'b1, 16'd102, "R9 back 01->11");
        quad_step(1'b0, 1'b0, 16'd102, "R9 skip 11->00 ignored");
        quad_step(1'b1, 1'b0, 16'd103, "R9 fwd after skip");

        // R10 overflow pulse
        wr_ctl(8'h00); wr_cnt(16'hFFFF); wr_ctl(8'hE0);
        peer_ovf_i = 1'b1; idle(1); peer_ovf_i = 1'b0;
        check("R10 wrap up value", count_o, 32'h0);
        check("R10 ovf pulse", ovf_o, 32'h1);
        check("R10 no unf on up wrap", unf_o, 32'h0);
        idle(1);
        check("R10 ovf one cycle", ovf_o, 32'h0);

        // R10 underflow pulse
        wr_ctl(8'h00); wr_cnt(16'h0000); wr_ctl(8'hA0);
        peer_ovf_i = 1'b1; idle(1); peer_ovf_i = 1'b0;
        check("R10 wrap down value", count_o, 32'hFFFF);
        check("R10 unf pulse", unf_o, 32'h1);
        check("R10 no ovf on down wrap", ovf_o, 32'h0);
        idle(1);
        check("R10 unf one cycle", unf_o, 32'h0);

        // R11 load beats a step, control write leaves count alone
        wr_ctl(8'h00); wr_cnt(16'h0007); wr_ctl(8'hE0);
        peer_ovf_i = 1'b1; cnt_we = 1'b1; cnt_wdata = 16'h5555;
        idle(1);
        peer_ovf_i = 1'b0; cnt_we = 1'b0;
        check("R11 load overrides step", count_o, 32'h5555);
        wr_ctl(8'h38);
        idle(5);
        check("R11 control write keeps count", count_o, 32'h5555);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule